// File: doc/BRIEF.md
# Queued Conversion Command Sequencer

This block steps an analog-to-digital front end through a queue of conversion commands. Software loads a table of command words. Each word names an input channel, a final-sample duration and an optional pause point. Software then chooses what starts the queue: a software strobe, a tick from an internal periodic timer, or a rising edge on an external trigger line. For each word the sequencer raises four one-hot stage controls in a fixed order and waits for the conversion core to report a result. It then stores that result in a result table at the same index as the command word.

A pass ends on one of two conditions: a word whose channel field holds the reserved end code, or the last table entry. When a word carries a pause mark, execution stops after that word and waits for a fresh trigger before the next word runs. The sequencer keeps three sticky status flags: pause reached, queue complete and trigger overrun. Software clears each flag by writing a one to it. The pause and complete flags can each raise the interrupt line when their enable is set. In single-scan operation a pass needs an explicit arming strobe first. In continuous operation the queue re-arms itself after every pass.

Top module: `conv_queue_seq`

## Requirements
- R1: `trigMode` picks the trigger source: 0 = `swStart` high at a clock edge, 1 = an internal timer tick every `TIMER_DIV` cycles, 2 = a rising edge of `extTrig` (low in one sampled cycle, high in the next), 3 = no source. Sources not selected have no effect.
- R2: With `continuous` low, a trigger starts a pass only after an `armSingle` strobe, and finishing a pass disarms the queue. With `continuous` high, the queue stays armed after each pass. Triggers seen while not armed change nothing.
- R3: A started word takes one decode cycle, then `sampleConnect` for 2 cycles, `transfer` for 2 cycles and `finalSample` for 2·2^code cycles, then `resolve` until `resValid` is sampled high. At most one stage output is high at a time, and all are low when idle, decoding or paused.
- R4: A command word is 9 bits: [5:0] channel, [7:6] final-sample code (0..3 give 2, 4, 8, 16 cycles), [8] pause mark. `channel` shows the word's channel while any stage output is high and reads 0 otherwise.
- R5: The `resData` sampled with `resValid` during the resolve stage is stored at the index of the current word and can be read combinationally through `resRdAddr`/`resRdData`.
- R6: After the result of a word with its pause mark set, the queue halts and `pauseFlag` sets. The next selected trigger resumes the queue with the following word.
- R7: A word whose channel is 63 (6'h3F) ends the pass during its decode cycle with no stage output raised, sets `doneFlag`, and the next pass starts at index 0.
- R8: Storing the result of the last entry (index `DEPTH-1`) ends the pass and sets `doneFlag`. A pause mark on that entry is ignored.
- R9: A selected trigger that arrives while a pass is running and not paused sets `overrunFlag` and does not alter the queue.
- R10: Reset clears all flags, idles the queue and disarms single scan. Writing `statusClr` bit 0/1/2 clears pause/done/overrun, and a set in the same cycle wins. `irq` = (`pauseFlag` & `pauseIe`) | (`doneFlag` & `doneIe`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Command table write enable |
| cmdWrAddr | input | $clog2(DEPTH) | Command table write index |
| cmdWrData | input | 9 | Command word |
| resRdAddr | input | $clog2(DEPTH) | Result table read index |
| resRdData | output | RES_W | Result table read data |
| trigMode | input | 2 | Trigger source select |
| continuous | input | 1 | Continuous scanning when high |
| armSingle | input | 1 | Arms one single-scan pass |
| swStart | input | 1 | Software trigger strobe |
| extTrig | input | 1 | External trigger line |
| pauseIe | input | 1 | Pause interrupt enable |
| doneIe | input | 1 | Completion interrupt enable |
| statusClr | input | 3 | Write-one-to-clear: bit0 pause, bit1 done, bit2 overrun |
| pauseFlag | output | 1 | Pause reached |
| doneFlag | output | 1 | Queue complete |
| overrunFlag | output | 1 | Trigger overrun |
| irq | output | 1 | Interrupt request |
| channel | output | 6 | Selected input channel |
| sampleConnect | output | 1 | Initial sample stage |
| transfer | output | 1 | Transfer stage |
| finalSample | output | 1 | Final sample stage |
| resolve | output | 1 | Resolution stage |
| resValid | input | 1 | Conversion result valid |
| resData | input | RES_W | Conversion result |

## Verification
A trigger sampled at edge k puts the queue into decode after k. `sampleConnect` rises after edge k+1, and each later stage rises exactly as many edges later as the one before it lasted. A flag sets at the same edge that samples `resValid` or the end word, and a table write is visible in the next decode. The bench's behavioural model advances on the same edge as the design. Outputs are compared 2 ns after every rising edge, when both have settled and before the next input change at the falling edge. Result-table contents and flag states are read back through the ports once the model reports the queue idle or paused.

// File: rtl/cqs_pkg.sv
package cqs_pkg;
  localparam int CHAN_W      = 6;
  localparam int CODE_W      = 2;
  localparam int CMD_W       = CHAN_W + CODE_W + 1;
  localparam int STAGE_CNT_W = 4;
  localparam logic [CHAN_W-1:0] END_CHAN = 6'h3F;

  typedef struct packed {
    logic              pause;
    logic [CODE_W-1:0] sampleCode;
    logic [CHAN_W-1:0] chan;
  } cmdWord_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_INIT, ST_XFER, ST_FINAL, ST_RES, ST_PAUSE
  } seqState_t;

  typedef enum logic [1:0] {
    TRIG_SW = 2'd0, TRIG_TIMER = 2'd1, TRIG_EXT = 2'd2, TRIG_OFF = 2'd3
  } trigSel_t;

  typedef struct packed {
    logic resWr;
    logic setPause;
    logic setDone;
    logic setOverrun;
    logic disarm;
  } ctlStrobe_t;
endpackage

// File: rtl/cqs_ctrl.sv
module cqs_ctrl
  import cqs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigEvent,
  input  logic               armed,
  input  cmdWord_t           tableWord,
  input  logic               resValid,
  output logic [IDX_W-1:0]   curIdx,
  output ctlStrobe_t         strb,
  output logic [CHAN_W-1:0]  channel,
  output logic               sampleConnect,
  output logic               transfer,
  output logic               finalSample,
  output logic               resolve
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  seqState_t               state;
  cmdWord_t                curWord;
  logic [STAGE_CNT_W-1:0]  stageCnt;
  logic                    isEnd;
  logic                    lastWord;
  logic                    stageOn;

  assign isEnd    = (tableWord.chan == END_CHAN);
  assign lastWord = (curIdx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curIdx   <= '0;
      stageCnt <= '0;
      curWord  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (trigEvent && armed) begin
          state  <= ST_CHECK;
          curIdx <= '0;
        end
        ST_CHECK: if (isEnd) begin
          state  <= ST_IDLE;
          curIdx <= '0;
        end else begin
          curWord  <= tableWord;
          state    <= ST_INIT;
          stageCnt <= STAGE_CNT_W'(1);
        end
        ST_INIT: if (stageCnt == '0) begin
          state    <= ST_XFER;
          stageCnt <= STAGE_CNT_W'(1);
        end else stageCnt <= stageCnt - 1'b1;
        ST_XFER: if (stageCnt == '0) begin
          state    <= ST_FINAL;
          stageCnt <= STAGE_CNT_W'((5'd2 << curWord.sampleCode) - 5'd1);
        end else stageCnt <= stageCnt - 1'b1;
        ST_FINAL: if (stageCnt == '0) state <= ST_RES;
                  else stageCnt <= stageCnt - 1'b1;
        ST_RES: if (resValid) begin
          if (lastWord) begin
            state  <= ST_IDLE;
            curIdx <= '0;
          end else begin
            state  <= curWord.pause ? ST_PAUSE : ST_CHECK;
            curIdx <= curIdx + 1'b1;
          end
        end
        ST_PAUSE: if (trigEvent) state <= ST_CHECK;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb            = '0;
    strb.resWr      = (state == ST_RES) && resValid;
    strb.setPause   = strb.resWr && curWord.pause && !lastWord;
    strb.setDone    = ((state == ST_CHECK) && isEnd) || (strb.resWr && lastWord);
    strb.disarm     = strb.setDone;
    strb.setOverrun = trigEvent && (state != ST_IDLE) && (state != ST_PAUSE);
  end

  assign sampleConnect = (state == ST_INIT);
  assign transfer      = (state == ST_XFER);
  assign finalSample   = (state == ST_FINAL);
  assign resolve       = (state == ST_RES);
  assign stageOn       = sampleConnect | transfer | finalSample | resolve;
  assign channel       = stageOn ? curWord.chan : '0;

  // R3
  init_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleConnect) |=> sampleConnect);
  // R3
  xfer_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(transfer) |-> $past(sampleConnect));
  // R3
  final_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(finalSample) |-> $past(transfer));
  // R3
  resolve_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resolve) |-> $past(resValid));
  // R7
  no_end_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleConnect |-> (channel != END_CHAN));
endmodule

// File: rtl/cqs_datapath.sv
module cqs_datapath
  import cqs_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int RES_W     = 10,
  parameter int TIMER_DIV = 1000,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int TMR_W = (TIMER_DIV > 2) ? $clog2(TIMER_DIV) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [IDX_W-1:0]  cmdWrAddr,
  input  logic [CMD_W-1:0]  cmdWrData,
  input  logic [IDX_W-1:0]  resRdAddr,
  output logic [RES_W-1:0]  resRdData,
  input  logic [1:0]        trigMode,
  input  logic              continuous,
  input  logic              armSingle,
  input  logic              swStart,
  input  logic              extTrig,
  input  logic              pauseIe,
  input  logic              doneIe,
  input  logic [2:0]        statusClr,
  input  logic [RES_W-1:0]  resData,
  input  logic [IDX_W-1:0]  curIdx,
  input  ctlStrobe_t        strb,
  output cmdWord_t          tableWord,
  output logic              trigEvent,
  output logic              armed,
  output logic              pauseFlag,
  output logic              doneFlag,
  output logic              overrunFlag,
  output logic              irq
);
  cmdWord_t         cmdMem [DEPTH];
  logic [RES_W-1:0] resMem [DEPTH];
  logic [TMR_W-1:0] tmrCnt;
  logic             tmrTick;
  logic             extPrev;
  logic             extEdge;
  logic             singleArmed;

  always_ff @(posedge clk) begin
    if (cmdWrEn) cmdMem[cmdWrAddr] <= cmdWord_t'(cmdWrData);
    if (strb.resWr) resMem[curIdx] <= resData;
  end
  assign tableWord = cmdMem[curIdx];
  assign resRdData = resMem[resRdAddr];

  assign tmrTick = (tmrCnt == TMR_W'(TIMER_DIV - 1));
  assign extEdge = extTrig && !extPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrCnt  <= '0;
      extPrev <= 1'b0;
    end else begin
      tmrCnt  <= tmrTick ? '0 : tmrCnt + 1'b1;
      extPrev <= extTrig;
    end
  end

  always_comb begin
    case (trigSel_t'(trigMode))
      TRIG_SW:    trigEvent = swStart;
      TRIG_TIMER: trigEvent = tmrTick;
      TRIG_EXT:   trigEvent = extEdge;
      default:    trigEvent = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            singleArmed <= 1'b0;
    else if (armSingle)   singleArmed <= 1'b1;
    else if (strb.disarm) singleArmed <= 1'b0;
  end
  assign armed = continuous | singleArmed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pauseFlag   <= 1'b0;
      doneFlag    <= 1'b0;
      overrunFlag <= 1'b0;
    end else begin
      if (strb.setPause)        pauseFlag <= 1'b1;
      else if (statusClr[0])    pauseFlag <= 1'b0;
      if (strb.setDone)         doneFlag <= 1'b1;
      else if (statusClr[1])    doneFlag <= 1'b0;
      if (strb.setOverrun)      overrunFlag <= 1'b1;
      else if (statusClr[2])    overrunFlag <= 1'b0;
    end
  end

  assign irq = (pauseFlag & pauseIe) | (doneFlag & doneIe);

  // R6
  pause_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setPause |=> pauseFlag);
  // R7
  done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setDone |=> doneFlag);
  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setOverrun |=> overrunFlag);
  // R2
  disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.disarm && !armSingle && !continuous) |=> !armed);
endmodule

// File: rtl/conv_queue_seq.sv
module conv_queue_seq
  import cqs_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int RES_W     = 10,
  parameter int TIMER_DIV = 1000,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [IDX_W-1:0]  cmdWrAddr,
  input  logic [8:0]        cmdWrData,
  input  logic [IDX_W-1:0]  resRdAddr,
  output logic [RES_W-1:0]  resRdData,
  input  logic [1:0]        trigMode,
  input  logic              continuous,
  input  logic              armSingle,
  input  logic              swStart,
  input  logic              extTrig,
  input  logic              pauseIe,
  input  logic              doneIe,
  input  logic [2:0]        statusClr,
  output logic              pauseFlag,
  output logic              doneFlag,
  output logic              overrunFlag,
  output logic              irq,
  output logic [5:0]        channel,
  output logic              sampleConnect,
  output logic              transfer,
  output logic              finalSample,
  output logic              resolve,
  input  logic              resValid,
  input  logic [RES_W-1:0]  resData
);
  logic [IDX_W-1:0] curIdx;
  ctlStrobe_t       strb;
  cmdWord_t         tableWord;
  logic             trigEvent;
  logic             armed;

  cqs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigEvent(trigEvent), .armed(armed),
    .tableWord(tableWord), .resValid(resValid), .curIdx(curIdx), .strb(strb),
    .channel(channel), .sampleConnect(sampleConnect), .transfer(transfer),
    .finalSample(finalSample), .resolve(resolve)
  );

  cqs_datapath #(.DEPTH(DEPTH), .RES_W(RES_W), .TIMER_DIV(TIMER_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrAddr(cmdWrAddr),
    .cmdWrData(cmdWrData), .resRdAddr(resRdAddr), .resRdData(resRdData),
    .trigMode(trigMode), .continuous(continuous), .armSingle(armSingle),
    .swStart(swStart), .extTrig(extTrig), .pauseIe(pauseIe), .doneIe(doneIe),
    .statusClr(statusClr), .resData(resData), .curIdx(curIdx), .strb(strb),
    .tableWord(tableWord), .trigEvent(trigEvent), .armed(armed),
    .pauseFlag(pauseFlag), .doneFlag(doneFlag), .overrunFlag(overrunFlag),
    .irq(irq)
  );
endmodule

// File: tb/tb_conv_queue_seq.sv
`timescale 1ns/1ps
module tb_conv_queue_seq;
  localparam int DEPTH = 16;
  localparam int RES_W = 10;
  localparam int TDIV  = 60;

  logic clk = 0;
  logic rstN = 0;
  logic cmdWrEn = 0;
  logic [3:0] cmdWrAddr = 0;
  logic [8:0] cmdWrData = 0;
  logic [3:0] resRdAddr = 0;
  logic [RES_W-1:0] resRdData;
  logic [1:0] trigMode = 0;
  logic continuous = 0, armSingle = 0, swStart = 0, extTrig = 0;
  logic pauseIe = 0, doneIe = 0;
  logic [2:0] statusClr = 0;
  logic pauseFlag, doneFlag, overrunFlag, irq;
  logic [5:0] channel;
  logic sampleConnect, transfer, finalSample, resolve;
  logic resValid = 0;
  logic [RES_W-1:0] resData = 0;

  always #4 clk = ~clk;

  conv_queue_seq #(.DEPTH(DEPTH), .RES_W(RES_W), .TIMER_DIV(TDIV)) dut (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrAddr(cmdWrAddr),
    .cmdWrData(cmdWrData), .resRdAddr(resRdAddr), .resRdData(resRdData),
    .trigMode(trigMode), .continuous(continuous), .armSingle(armSingle),
    .swStart(swStart), .extTrig(extTrig), .pauseIe(pauseIe), .doneIe(doneIe),
    .statusClr(statusClr), .pauseFlag(pauseFlag), .doneFlag(doneFlag),
    .overrunFlag(overrunFlag), .irq(irq), .channel(channel),
    .sampleConnect(sampleConnect), .transfer(transfer), .finalSample(finalSample),
    .resolve(resolve), .resValid(resValid), .resData(resData)
  );

  int checks = 0, fails = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model: 0 idle, 1 decode, 2 init, 3 transfer, 4 final, 5 resolve, 6 paused
  int mState, mIdx, mLeft, mTcnt, mChan, mCode;
  bit mPause, mSingle, mExtPrev, mPf, mDf, mOf;
  logic [8:0] mTable [DEPTH];
  int mRes [DEPTH];

  always @(posedge clk) begin
    bit trig, tick, sP, sD, sO, armedNow;
    logic [8:0] w;
    if (!rstN) begin
      mState = 0; mIdx = 0; mLeft = 0; mTcnt = 0; mChan = 0; mCode = 0;
      mPause = 0; mSingle = 0; mExtPrev = 0; mPf = 0; mDf = 0; mOf = 0;
    end else begin
      tick = (mTcnt == TDIV - 1);
      case (trigMode)
        2'd0: trig = swStart;
        2'd1: trig = tick;
        2'd2: trig = extTrig && !mExtPrev;
        default: trig = 0;
      endcase
      mTcnt = tick ? 0 : mTcnt + 1;
      mExtPrev = extTrig;
      armedNow = continuous || mSingle;
      sP = 0; sD = 0;
      sO = trig && mState != 0 && mState != 6;
      case (mState)
        0: if (trig && armedNow) begin mState = 1; mIdx = 0; end
        1: begin
          w = mTable[mIdx];
          if (w[5:0] == 6'h3F) begin sD = 1; mState = 0; mIdx = 0; end
          else begin
            mChan = w[5:0]; mCode = w[7:6]; mPause = w[8];
            mState = 2; mLeft = 2;
          end
        end
        2: begin mLeft--; if (mLeft == 0) begin mState = 3; mLeft = 2; end end
        3: begin mLeft--; if (mLeft == 0) begin mState = 4; mLeft = 2 << mCode; end end
        4: begin mLeft--; if (mLeft == 0) mState = 5; end
        5: if (resValid) begin
          mRes[mIdx] = resData;
          if (mIdx == DEPTH - 1) begin sD = 1; mState = 0; mIdx = 0; end
          else begin
            if (mPause) begin sP = 1; mState = 6; end else mState = 1;
            mIdx++;
          end
        end
        6: if (trig) mState = 1;
        default: mState = 0;
      endcase
      if (armSingle) mSingle = 1; else if (sD) mSingle = 0;
      mPf = sP ? 1 : (statusClr[0] ? 0 : mPf);
      mDf = sD ? 1 : (statusClr[1] ? 0 : mDf);
      mOf = sO ? 1 : (statusClr[2] ? 0 : mOf);
      if (cmdWrEn) mTable[cmdWrAddr] = cmdWrData;
    end
  end

  // Per-cycle comparison, 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    chk("R3 sampleConnect", sampleConnect, mState == 2);
    chk("R3 transfer", transfer, mState == 3);
    chk("R3 finalSample", finalSample, mState == 4);
    chk("R3 resolve", resolve, mState == 5);
    chk("R4 channel", channel, (mState >= 2 && mState <= 5) ? mChan : 0);
    chk("R6 pauseFlag", pauseFlag, mPf);
    chk("R7 doneFlag", doneFlag, mDf);
    chk("R9 overrunFlag", overrunFlag, mOf);
    chk("R10 irq", irq, (mPf && pauseIe) || (mDf && doneIe));
  end

  // Conversion core stand-in: result 3 cycles into resolve
  int rc = 0, seq = 0;
  always @(negedge clk) begin
    if (resolve && !resValid) begin
      rc++;
      if (rc == 3) begin
        resValid <= 1;
        resData  <= {channel, 4'(seq)};
        seq++;
        rc = 0;
      end
    end else resValid <= 0;
  end

  task automatic putWord(input int idx, input bit p, input int code, input int ch);
    @(negedge clk);
    cmdWrEn = 1; cmdWrAddr = 4'(idx); cmdWrData = {p, 2'(code), 6'(ch)};
    @(negedge clk);
    cmdWrEn = 0;
  endtask

  task automatic pulseSw();
    @(negedge clk); swStart = 1; @(negedge clk); swStart = 0;
  endtask

  task automatic pulseArm();
    @(negedge clk); armSingle = 1; @(negedge clk); armSingle = 0;
  endtask

  task automatic clearFlags(input logic [2:0] m);
    @(negedge clk); statusClr = m; @(negedge clk); statusClr = 0;
  endtask

  task automatic waitState(input int s);
    int n = 0;
    @(negedge clk);
    while (mState != s && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic checkResults(input string req, input int upto);
    for (int i = 0; i < upto; i++) begin
      @(negedge clk); resRdAddr = 4'(i); #1;
      chk(req, resRdData, mRes[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R10 reset state
    chk("R10 reset pauseFlag", pauseFlag, 0);
    chk("R10 reset doneFlag", doneFlag, 0);
    chk("R10 reset overrunFlag", overrunFlag, 0);
    pauseIe = 1; doneIe = 1;

    putWord(0, 0, 0, 5);
    putWord(1, 1, 1, 9);
    putWord(2, 0, 3, 12);
    putWord(3, 0, 2, 20);
    putWord(4, 0, 0, 63);

    // R2: not armed, software start ignored
    trigMode = 2'd0;
    pulseSw();
    repeat (20) @(negedge clk);
    chk("R2 unarmed stays idle", sampleConnect | doneFlag, 0);

    pulseArm();
    pulseSw();
    repeat (6) @(negedge clk);
    pulseSw();                       // R9 trigger while running
    waitState(6);
    chk("R6 paused flag", pauseFlag, 1);
    chk("R9 overrun flag", overrunFlag, 1);
    chk("R10 irq from pause", irq, 1);
    clearFlags(3'b101);
    chk("R10 clear pause", pauseFlag, 0);
    pulseSw();
    waitState(0);
    repeat (2) @(negedge clk);
    chk("R7 end word done", doneFlag, 1);
    checkResults("R5 result table", 4);

    // R2: disarmed after pass
    clearFlags(3'b111);
    pulseSw();
    repeat (30) @(negedge clk);
    chk("R2 disarmed after pass", doneFlag, 0);

    // R1 external edge, continuous, R8 last entry
    putWord(4, 0, 0, 30);
    for (int i = 5; i < 15; i++) putWord(i, 0, i % 4, i + 20);
    putWord(15, 1, 1, 50);
    trigMode = 2'd2; continuous = 1;
    pulseSw();
    repeat (10) @(negedge clk);
    chk("R1 sw ignored in ext mode", sampleConnect | transfer, 0);
    @(negedge clk); extTrig = 1;
    waitState(6);
    repeat (30) @(negedge clk);
    chk("R1 held level no resume", pauseFlag & !transfer & !sampleConnect, 1);
    clearFlags(3'b001);
    @(negedge clk); extTrig = 0;
    @(negedge clk); extTrig = 1;
    waitState(0);
    repeat (2) @(negedge clk);
    chk("R8 last entry done", doneFlag, 1);
    chk("R8 pause on last ignored", pauseFlag, 0);
    checkResults("R5 full table", DEPTH);
    extTrig = 0;

    // R1 timer source, continuous passes
    putWord(2, 0, 0, 63);
    clearFlags(3'b111);
    trigMode = 2'd1;
    repeat (500) @(negedge clk);
    waitState(0);
    trigMode = 2'd3;
    repeat (2) @(negedge clk);
    chk("R1 timer pass done", doneFlag, 1);
    checkResults("R5 timer results", 2);

    // R1 no source
    clearFlags(3'b111);
    pulseSw();
    @(negedge clk); extTrig = 1;
    repeat (200) @(negedge clk);
    chk("R1 mode 3 ignores all", doneFlag | pauseFlag | sampleConnect, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule